// File: doc/BRIEF.md
# Common-Clock True Dual-Port RAM with Selectable Write Behaviour

This block is a synthesizable behavioural model of a two-port synchronous memory. Both ports share one clock, and either port can read or write any location. Each port has an enable, a write strobe, an address and input data. Its output register loads once per enabled access, so read data appears one clock edge after the address is presented.

Each port has its own parameter that sets what its output register does while that port writes. In new-data mode the output shows the value just written. In old-data mode it shows the value that was overwritten. In keep mode it holds its previous value.

The model also watches for accesses to the same address by both ports on the same edge. It raises a one-cycle flag for every combination whose result is unreliable. When a read is unreliable, the reading port's output is loaded with unknown bits.

The ports are plain per-cycle access pins rather than streams. Every enabled access is taken on the edge where it is presented, and there is no back-pressure.

Top module: `twin_port_ram`

## Requirements
- R1: An enabled read with the write strobe low (en=1, we=0) loads the stored word at the address into that port's output. The value is visible after that single clock edge.
- R2: A port in new-data mode (WM_NEW) that writes shows the written input data on its output after the edge.
- R3: A port in old-data mode (WM_OLD) that writes shows the contents the location held before the edge.
- R4: A port in keep mode (WM_KEEP) that writes leaves its output unchanged. The write still lands in memory.
- R5: While a port's enable is low, that port writes nothing, even with its write strobe high, and its output holds.
- R6: Both ports reading the same address on the same edge each receive the stored word, and no flag rises.
- R7: Both ports writing the same address on the same edge store the word without a flag if the two data words are identical. If they differ, `clash_wr` is 1 for exactly the cycle after that edge, and the location's contents become undefined.
- R8: One port writes and the other reads the same address on the same edge. If the writer is in WM_OLD, the reader receives the old contents and no flag rises. Otherwise the reader's flag (`clash_rd_a` for port A reading, `clash_rd_b` for port B reading) is 1 for the next cycle only, and the reader's output is unknown.
- R9: Memory holds zero at start-up. A synchronous active-high reset clears both outputs and all three flags and leaves memory contents intact.
- R10: Writes from both ports to different addresses on the same edge both land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous reset, active high; clears outputs and flags |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write strobe (used only with a_en) |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Port A registered output |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write strobe (used only with b_en) |
| b_addr | input | ADDR_W | Port B word address |
| b_din | input | DATA_W | Port B write data |
| b_dout | output | DATA_W | Port B registered output |
| clash_rd_a | output | 1 | Port A's last read was unreliable |
| clash_rd_b | output | 1 | Port B's last read was unreliable |
| clash_wr | output | 1 | Last edge had conflicting same-address writes |

## Verification
The assertions check the following on every cycle:
- an idle port holds its output;
- a keep-mode write holds the output;
- a new-data write reproduces its input;
- each flag rises only after an edge that carried the matching same-address combination;
- a read never reports a clash against an old-data writer.

Only the bench scenarios can show the following:
- that the stored word actually reaches the output;
- that old-data mode returns the overwritten value;
- that disabled writes leave memory untouched;
- that identical dual writes are stored;
- that reset spares the memory contents.

The bench runs two instances with different mode pairs so that every writer mode meets a same-address reader.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  // Output behaviour of a port during its own write
  typedef enum logic [1:0] {
    WM_NEW  = 2'd0,  // show data being written
    WM_OLD  = 2'd1,  // show contents being replaced
    WM_KEEP = 2'd2   // hold previous output
  } wmode_e;
endpackage

// File: rtl/tpr_clash_detect.sv
module tpr_clash_detect #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter tpr_pkg::wmode_e MODE_A = tpr_pkg::WM_NEW,
  parameter tpr_pkg::wmode_e MODE_B = tpr_pkg::WM_OLD
) (
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  output logic              rd_bad_a,
  output logic              rd_bad_b,
  output logic              wr_bad
);
  localparam bit A_SAFE = (MODE_A == tpr_pkg::WM_OLD);
  localparam bit B_SAFE = (MODE_B == tpr_pkg::WM_OLD);

  logic same, a_wr, b_wr, a_rd, b_rd;

  always_comb begin
    same = (a_addr == b_addr);
    a_wr = a_en && a_we;
    b_wr = b_en && b_we;
    a_rd = a_en && !a_we;
    b_rd = b_en && !b_we;
    // a reader is harmed only when the writer is not in old-data mode
    rd_bad_b = same && a_wr && b_rd && !A_SAFE;
    rd_bad_a = same && b_wr && a_rd && !B_SAFE;
    wr_bad   = same && a_wr && b_wr && (a_din != b_din);
  end
endmodule

// File: rtl/tpr_port_out.sv
module tpr_port_out #(
  parameter int DATA_W = 16,
  parameter tpr_pkg::wmode_e MODE = tpr_pkg::WM_NEW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] stored,
  input  logic              poison,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (en) begin
      if (poison) begin
        dout <= 'x;
      end else if (!we) begin
        dout <= stored;
      end else begin
        case (MODE)
          tpr_pkg::WM_NEW:  dout <= din;
          tpr_pkg::WM_OLD:  dout <= stored;
          default:          dout <= dout;
        endcase
      end
    end
  end

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout));

  p_keep_on_write_r4: assert property (@(posedge clk) disable iff (rst)
    (MODE == tpr_pkg::WM_KEEP && en && we && !poison) |=> $stable(dout));

  p_new_on_write_r2: assert property (@(posedge clk) disable iff (rst)
    (MODE == tpr_pkg::WM_NEW && en && we && !poison) |=> (dout == $past(din)));
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter tpr_pkg::wmode_e MODE_A = tpr_pkg::WM_NEW,
  parameter tpr_pkg::wmode_e MODE_B = tpr_pkg::WM_OLD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  output logic              clash_rd_a,
  output logic              clash_rd_b,
  output logic              clash_wr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] a_stored, b_stored;
  logic rd_bad_a, rd_bad_b, wr_bad;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  assign a_stored = mem[a_addr];
  assign b_stored = mem[b_addr];

  tpr_clash_detect #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_A(MODE_A), .MODE_B(MODE_B)
  ) u_clash (
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din),
    .rd_bad_a(rd_bad_a), .rd_bad_b(rd_bad_b), .wr_bad(wr_bad)
  );

  // storage: conflicting same-address writes leave the word undefined
  always_ff @(posedge clk) begin
    if (a_en && a_we) mem[a_addr] <= a_din;
    if (b_en && b_we) mem[b_addr] <= b_din;
    if (wr_bad)       mem[a_addr] <= 'x;
  end

  tpr_port_out #(.DATA_W(DATA_W), .MODE(MODE_A)) u_out_a (
    .clk(clk), .rst(rst), .en(a_en), .we(a_we), .din(a_din),
    .stored(a_stored), .poison(rd_bad_a), .dout(a_dout)
  );

  tpr_port_out #(.DATA_W(DATA_W), .MODE(MODE_B)) u_out_b (
    .clk(clk), .rst(rst), .en(b_en), .we(b_we), .din(b_din),
    .stored(b_stored), .poison(rd_bad_b), .dout(b_dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clash_rd_a <= 1'b0;
      clash_rd_b <= 1'b0;
      clash_wr   <= 1'b0;
    end else begin
      clash_rd_a <= rd_bad_a;
      clash_rd_b <= rd_bad_b;
      clash_wr   <= wr_bad;
    end
  end

  p_rd_flag_b_cause_r8: assert property (@(posedge clk) disable iff (rst)
    clash_rd_b |-> $past(a_en && a_we && b_en && !b_we && a_addr == b_addr));

  p_rd_flag_a_cause_r8: assert property (@(posedge clk) disable iff (rst)
    clash_rd_a |-> $past(b_en && b_we && a_en && !a_we && a_addr == b_addr));

  p_old_writer_safe_r8: assert property (@(posedge clk) disable iff (rst)
    (MODE_A == tpr_pkg::WM_OLD) |-> !clash_rd_b);

  p_wr_flag_cause_r7: assert property (@(posedge clk) disable iff (rst)
    clash_wr |-> $past(a_en && a_we && b_en && b_we && a_addr == b_addr && a_din != b_din));
endmodule

// File: tb/twin_port_ram_bench.sv
module twin_port_ram_bench;
  localparam int PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_din = '0, b_din = '0;
  logic [DW-1:0] a1, b1, a2, b2;
  logic cra1, crb1, cw1, cra2, crb2, cw2;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  // instance 1: A new-data, B old-data
  twin_port_ram #(.ADDR_W(AW), .DATA_W(DW),
    .MODE_A(tpr_pkg::WM_NEW), .MODE_B(tpr_pkg::WM_OLD)) u_twin_port_ram (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_dout(a1),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_dout(b1),
    .clash_rd_a(cra1), .clash_rd_b(crb1), .clash_wr(cw1));

  // instance 2: A keep, B new-data
  twin_port_ram #(.ADDR_W(AW), .DATA_W(DW),
    .MODE_A(tpr_pkg::WM_KEEP), .MODE_B(tpr_pkg::WM_NEW)) u_twin_port_ram_alt (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_dout(a2),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_dout(b2),
    .clash_rd_a(cra2), .clash_rd_b(crb2), .clash_wr(cw2));

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present both ports at a negedge, then wait to the next negedge
  task automatic step(input logic ae, aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                      input logic be, bw, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
    a_en = ae; a_we = aw; a_addr = aa; a_din = ad;
    b_en = be; b_we = bw; b_addr = ba; b_din = bd;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    check("R9 a_dout after reset", a1, 16'h0);
    check("R9 b_dout after reset", b1, 16'h0);
    check("R9 flags after reset", {13'b0, cra1, crb1, cw1}, 16'h0);
    rst = 0;
    step(1, 0, 5, 0, 1, 0, 6, 0);
    check("R9 zero-initialised memory", a1, 16'h0);
    check("R9 zero-initialised memory port b", b1, 16'h0);
  endtask

  task automatic t_two_writes();
    step(1, 1, 3, 16'h1111, 1, 1, 4, 16'h2222);
    check("R2 new-data write shows din", a1, 16'h1111);
    check("R3 old-data write shows prior word", b1, 16'h0000);
    step(1, 0, 4, 0, 1, 0, 3, 0);
    check("R10 port B write landed", a1, 16'h2222);
    check("R1 read returns stored word", b1, 16'h1111);
  endtask

  task automatic t_old_mode();
    step(0, 0, 0, 0, 1, 1, 3, 16'h3333);
    check("R3 old-data write returns replaced word", b1, 16'h1111);
    check("R2 new-data port B shows written data", b2, 16'h3333);
  endtask

  task automatic t_keep_mode();
    step(1, 0, 4, 0, 0, 0, 0, 0);
    check("R1 read before keep write", a2, 16'h2222);
    step(1, 1, 4, 16'h4444, 0, 0, 0, 0);
    check("R4 keep-mode output unchanged", a2, 16'h2222);
    check("R2 new-data output follows write", a1, 16'h4444);
  endtask

  task automatic t_disabled();
    step(0, 1, 4, 16'h5555, 0, 1, 3, 16'h5A5A);
    check("R5 disabled port A holds output", a1, 16'h4444);
    check("R5 disabled port B holds output", b1, 16'h1111);
    step(1, 0, 4, 0, 1, 0, 3, 0);
    check("R5 disabled write left word A", a1, 16'h4444);
    check("R5 disabled write left word B", b1, 16'h3333);
  endtask

  task automatic t_shared_read();
    step(1, 0, 3, 0, 1, 0, 3, 0);
    check("R6 port A same-address read", a1, 16'h3333);
    check("R6 port B same-address read", b1, 16'h3333);
    check("R6 no flags", {13'b0, cra1, crb1, cw1}, 16'h0);
  endtask

  task automatic t_write_vs_read();
    // B writes 3, A reads 3: inst1 B old-data -> safe; inst2 B new-data -> clash
    step(1, 0, 3, 0, 1, 1, 3, 16'h6666);
    check("R8 reader gets old word from old-data writer", a1, 16'h3333);
    check("R8 no flag with old-data writer", {15'b0, cra1}, 16'h0);
    check("R8 flag with new-data writer", {15'b0, cra2}, 16'h1);
    idle();
    check("R8 flag lasts one cycle", {15'b0, cra2}, 16'h0);
    // A writes 4, B reads 4: inst1 A new-data, inst2 A keep -> both clash
    step(1, 1, 4, 16'h7777, 1, 0, 4, 0);
    check("R8 flag with new-data writer on A", {15'b0, crb1}, 16'h1);
    check("R8 flag with keep writer on A", {15'b0, crb2}, 16'h1);
    idle();
    check("R8 port B flag clears", {14'b0, crb1, crb2}, 16'h0);
  endtask

  task automatic t_dual_write();
    step(1, 1, 8, 16'h1234, 1, 1, 8, 16'h1234);
    check("R7 identical writes raise no flag", {15'b0, cw1}, 16'h0);
    step(1, 0, 8, 0, 0, 0, 0, 0);
    check("R7 identical writes stored", a1, 16'h1234);
    step(1, 1, 9, 16'hAAAA, 1, 1, 9, 16'hBBBB);
    check("R7 differing writes flag", {15'b0, cw1}, 16'h1);
    idle();
    check("R7 write flag lasts one cycle", {15'b0, cw1}, 16'h0);
  endtask

  task automatic t_reset_keeps_memory();
    rst = 1;
    @(negedge clk);
    check("R9 reset clears a_dout", a1, 16'h0);
    rst = 0;
    step(1, 0, 3, 0, 1, 0, 4, 0);
    check("R9 memory survives reset (A)", a1, 16'h6666);
    check("R9 memory survives reset (B)", b1, 16'h7777);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_two_writes();
    t_old_mode();
    t_keep_mode();
    t_disabled();
    t_shared_read();
    t_write_vs_read();
    t_dual_write();
    t_reset_keeps_memory();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule